// File: doc/BRIEF.md
# Half-Integer Ratio Clock Divider

This block makes a slower clock from a faster one. The ratio is selectable and may be a half-integer. The block runs on a sampling clock `clk_i` at twice the rate of the notional input clock, so each sampling cycle is one half-period of the input. Rising edges of the input clock fall on the even-numbered sampling cycles, counted from the first active cycle after reset. The ratio arrives as a 6-bit code equal to twice the ratio. The legal set is every code from 3 to 16, which gives ratios 1.5 to 8 in steps of 0.5, and every even code from 18 to 32, which gives the integer ratios 9 to 16.

An odd code gives an output period that is an odd number of sampling cycles. In the low-frequency mode, a copy of the output delayed by half a sampling cycle stretches the high phase by that half cycle, so the duty is exactly 50%. In the high-frequency mode that stretch is switched off, so the high phase is slightly shorter than half the period. The parameter `PRE_HALVE` adds a divide-by-two in front of the divider, which doubles every duration. The ratio code and the mode are sampled only at the start of each output period, so a change while running takes effect at the next period start.

Top module: `halfstep_clkdiv`

## Requirements
- R1: While `rst_n` is low the output is low, and the state is cleared at once when `rst_n` falls. After release, the output stays low until the third rising sampling edge, and the first output period begins on that edge.
- R2: For a legal code C (with PRE_HALVE=0), each output period lasts exactly C sampling cycles and starts with a rising output edge on a rising sampling edge.
- R3: For an even code C, the output is high for exactly C/2 sampling cycles of each period, in both modes.
- R4: For an odd code C in the low-frequency mode (`hf_mode_i`=0), the output is high for C/2 sampling cycles. It falls on the falling sampling edge in the middle of cycle (C-1)/2 of the period.
- R5: For an odd code C in the high-frequency mode (`hf_mode_i`=1), the output is high for (C-1)/2 sampling cycles, which is less than half the period.
- R6: Any code outside the legal set (0 to 2, odd codes 17 to 31, and codes 33 to 63) behaves exactly like code 4.
- R7: The ratio code and the mode are sampled only on the edge that starts a period. Changes in mid-period do not alter the period in progress.
- R8: For an even code, every rising output edge falls on an even-numbered sampling cycle, that is, on a rising edge of the input clock.
- R9: With PRE_HALVE=1, the period is 2·C sampling cycles. The high time is C cycles, except for an odd code in the high-frequency mode, where it is C-1 cycles. The first period still starts on the third rising sampling edge after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock at twice the input clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_i | input | 6 | Ratio code, twice the division ratio |
| hf_mode_i | input | 1 | 1 selects high-frequency mode (shortened high time for odd codes) |
| clk_div_o | output | 1 | Divided clock |

## Verification
On every cycle, the assertions check the following: the period register only ever holds a legal length, the count stays below it, and the period and stretch setting stay fixed until the period's last cycle. They also check that the internal high phase starts at count zero and ends at half the period, and that the half-cycle stretch follows the undelayed phase and is active only for odd codes in the low-frequency mode. Only the bench's reference model can show the duty and period as seen at the output pin at half-cycle resolution. The same holds for the substitution of illegal codes, the reset-release latency, the mid-period ratio changes and the doubled timing of the pre-halving variant. The model samples twice per sampling cycle, once in each half, and runs against both variants at once.

// File: rtl/halfstep_pkg.sv
package halfstep_pkg;
  localparam int CODE_W    = 6;
  localparam int CODE_MIN  = 3;
  localparam int HALF_TOP  = 16;
  localparam int CODE_MAX  = 32;
  localparam int FALLBACK  = 4;
  localparam int CNT_W     = $clog2(CODE_MAX + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t legal_period(input logic [CODE_W-1:0] code);
    logic ok;
    ok = ((int'(code) >= CODE_MIN) && (int'(code) <= HALF_TOP)) ||
         ((int'(code) > HALF_TOP) && (int'(code) <= CODE_MAX) && !code[0]);
    return ok ? cnt_t'(code) : cnt_t'(FALLBACK);
  endfunction
endpackage

// File: rtl/halfstep_rst_sync.sv
module halfstep_rst_sync (
  input  logic clk_i,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/halfstep_tick.sv
module halfstep_tick #(
  parameter bit PRE_HALVE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n,
  output logic tick_en_o
);
  localparam logic HALVE_BIT = PRE_HALVE;

  logic ph_q;
  logic ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign tick_en_o = ~(ph_q & HALVE_BIT);
endmodule

// File: rtl/halfstep_core.sv
module halfstep_core
  import halfstep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              tick_en_i,
  input  logic [CODE_W-1:0] ratio_i,
  input  logic              hf_mode_i,
  output logic              q_pos_o,
  output logic              xhalf_o
);
  cnt_t cnt_q, cnt_d;
  cnt_t per_q, per_d;
  logic first_q, first_d;
  logic q_q, q_d;
  logic xh_q, xh_d;
  cnt_t per_sel;
  cnt_t cnt_inc;
  logic wrap;

  always_comb begin
    per_sel = legal_period(ratio_i);
    cnt_inc = cnt_q + cnt_t'(1);
    wrap    = first_q || (cnt_q == per_q - cnt_t'(1));
    cnt_d   = cnt_q;
    per_d   = per_q;
    first_d = first_q;
    q_d     = q_q;
    xh_d    = xh_q;
    if (tick_en_i) begin
      first_d = 1'b0;
      if (wrap) begin
        cnt_d = '0;
        per_d = per_sel;
        xh_d  = per_sel[0] & ~hf_mode_i;
        q_d   = 1'b1;
      end else begin
        cnt_d = cnt_inc;
        q_d   = cnt_inc < (per_q >> 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= cnt_t'(FALLBACK);
      first_q <= 1'b1;
      q_q     <= 1'b0;
      xh_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      first_q <= first_d;
      q_q     <= q_d;
      xh_q    <= xh_d;
    end
  end

  assign q_pos_o = q_q;
  assign xhalf_o = xh_q;

  assert_period_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !first_q |-> ((per_q >= cnt_t'(CODE_MIN)) && (per_q <= cnt_t'(CODE_MAX)) &&
                  ((per_q <= cnt_t'(HALF_TOP)) || !per_q[0])));

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !first_q |-> (cnt_q < per_q));

  assert_rise_at_start_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(q_q) |-> (cnt_q == '0));

  assert_fall_at_half_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(q_q) |-> (cnt_q == (per_q >> 1)));

  assert_hold_setting_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!first_q && (cnt_q != per_q - cnt_t'(1))) |=> ($stable(per_q) && $stable(xh_q)));
endmodule

// File: rtl/halfstep_ext.sv
module halfstep_ext #(
  parameter bit PRE_HALVE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic q_pos_i,
  input  logic xhalf_i,
  output logic q_ext_o
);
  logic ext_d;
  logic ext_q;

  always_comb ext_d = q_pos_i & xhalf_i;

  generate
    if (PRE_HALVE) begin : g_full_cycle
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_d;
      end

      assert_ext_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
        ext_q |-> $past(q_pos_i));
    end else begin : g_half_cycle
      always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_d;
      end

      assert_ext_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
        ext_q |-> q_pos_i);
    end
  endgenerate

  assert_ext_only_odd_low_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ext_q |-> xhalf_i);

  assign q_ext_o = ext_q;
endmodule

// File: rtl/halfstep_clkdiv.sv
module halfstep_clkdiv
  import halfstep_pkg::*;
#(
  parameter bit PRE_HALVE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_i,
  input  logic              hf_mode_i,
  output logic              clk_div_o
);
  logic rst_sync_n;
  logic tick_en;
  logic q_pos;
  logic xhalf;
  logic q_ext;

  halfstep_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  halfstep_tick #(.PRE_HALVE(PRE_HALVE)) u_tick (
    .clk_i     (clk_i),
    .rst_n     (rst_sync_n),
    .tick_en_o (tick_en)
  );

  halfstep_core u_core (
    .clk_i     (clk_i),
    .rst_n     (rst_sync_n),
    .tick_en_i (tick_en),
    .ratio_i   (ratio_i),
    .hf_mode_i (hf_mode_i),
    .q_pos_o   (q_pos),
    .xhalf_o   (xhalf)
  );

  halfstep_ext #(.PRE_HALVE(PRE_HALVE)) u_ext (
    .clk_i   (clk_i),
    .rst_n   (rst_sync_n),
    .q_pos_i (q_pos),
    .xhalf_i (xhalf),
    .q_ext_o (q_ext)
  );

  assign clk_div_o = q_pos | q_ext;

  assert_low_in_reset_R1: assert property (@(posedge clk_i)
    !rst_sync_n |-> !clk_div_o);
endmodule

// File: tb/halfstep_clkdiv_tb_top.sv
module halfstep_clkdiv_tb_top;
  logic       clk;
  logic       rst_n;
  logic [5:0] ratio;
  logic       hf;
  logic       div1;
  logic       div2;
  int         checks;
  int         errors;
  string      cur_tag;
  bit         done;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  halfstep_clkdiv #(.PRE_HALVE(1'b0)) dut_i (
    .clk_i(clk), .rst_n(rst_n), .ratio_i(ratio), .hf_mode_i(hf), .clk_div_o(div1));

  halfstep_clkdiv #(.PRE_HALVE(1'b1)) dut_half_i (
    .clk_i(clk), .rst_n(rst_n), .ratio_i(ratio), .hf_mode_i(hf), .clk_div_o(div2));

  task automatic cmp(input int s, input bit exp_v);
    logic act;
    act = (s == 1) ? div1 : div2;
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s%s t=%0t actual=%b expected=%b", cur_tag,
               (s == 2) ? "/R9" : "", $time, act, exp_v);
    end
  endtask

  // Reference: times in half-cycle slots; period 2*C*s, high C*s or (C-1)*s.
  task automatic model(input int s);
    int  edges = 0;
    bit  run = 0;
    int  slot = 0;
    int  per_h = 0;
    int  high_h = 0;
    int  code;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        run = 0; edges = 0;
      end else begin
        if (run) begin
          slot += 2;
        end else begin
          edges++;
        end
        if ((run && slot >= per_h) || (!run && edges == 3)) begin
          run  = 1;
          slot = 0;
          code = int'(ratio);
          if (!((code >= 3 && code <= 16) || (code > 16 && code <= 32 && code % 2 == 0)))
            code = 4; // R6
          per_h  = 2 * code * s;
          high_h = (code % 2 == 1 && hf) ? (code - 1) * s : code * s;
        end
      end
      #5;
      cmp(s, run && (slot < high_h));
      #10;
      if (!rst_n) begin
        run = 0; edges = 0;
      end
      cmp(s, run && (slot + 1 < high_h));
    end
  endtask

  task automatic apply(input int code, input bit mode, input int n, input string tag);
    @(negedge clk);
    ratio   = 6'(code);
    hf      = mode;
    cur_tag = tag;
    repeat (n) @(negedge clk);
  endtask

  initial model(1);
  initial model(2);

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; ratio = 6'd4; hf = 1'b0; cur_tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    apply(4,  0, 24, "R3");
    apply(10, 1, 40, "R3/R8");
    apply(12, 0, 48, "R8");
    apply(3,  0, 24, "R4");
    apply(7,  0, 42, "R4");
    apply(15, 0, 60, "R4");
    apply(3,  1, 24, "R5");
    apply(9,  1, 45, "R5");
    apply(13, 1, 52, "R5");
    apply(16, 0, 64, "R2");
    apply(32, 1, 130, "R2");
    apply(24, 0, 100, "R2");
    apply(17, 0, 40, "R6");
    apply(0,  1, 40, "R6");
    apply(2,  0, 40, "R6");
    apply(63, 1, 40, "R6");
    apply(33, 0, 40, "R6");
    apply(32, 0, 7, "R7");
    for (int i = 0; i < 12; i++) apply(3 + 2 * i, i % 2, 5 + i, "R7");
    apply(5, 0, 30, "R7");
    @(negedge clk);
    rst_n = 1'b0; cur_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule